// File: doc/BRIEF.md
# Register File Read Cross-Check Unit

This unit sits next to a register file that has several read ports. Each qualifying read that the pipeline makes through a port (the "primary" read) is logged as a pending check holding the address, the value returned and the port number. The unit later reads the same address again through a different port and compares the two values. Any difference raises a one-cycle exception that carries the register address and the port of the primary read. This exposes a port or bitline that returns corrupted data.

The unit has two run-time modes. In reserved mode (`mode_i` = 0) the highest-numbered port belongs to the unit. Checks issue there every cycle and never stall the pipeline's own reads on the other ports. In borrow mode (`mode_i` = 1) the unit takes, for one check, the lowest-numbered port that the pipeline leaves idle in that cycle. It flags that port as busy for the following compare cycle. When every port is in use, no port is taken and the check waits in a small queue. If the queue is full, the check is dropped and counted. An optional filter limits checking to one protected register address.

The register file is modelled as having a one-cycle read latency: data for a read issued in cycle t is on `rf_data_i` in cycle t+1.

Top module: `regfile_read_checker`

## Requirements
- R1: In borrow mode, a qualifying primary read of address A on port p, presented alone in cycle t, produces a verification read of A in cycle t+2. That read uses the lowest-numbered port q that is not port p, that the pipeline does not request in t+2, and that is not in its compare cycle.
- R2: If the verification value differs from the logged primary value, `exc_o` is high for exactly one cycle, four cycles after the primary request (when the check issued at the earliest time). `exc_addr_o` and `exc_port_o` then give A and p. Equal values raise no exception.
- R3: In reserved mode, port NPORT-1 (port 3 by default) is reserved: `busy_o[NPORT-1]` stays 1, and a pipeline request on that port never reaches `rf_en_o[NPORT-1]`. A check issues on that port in cycle t+2 even when the pipeline requests all the other ports.
- R4: In borrow mode, the unit takes at most one port per cycle, and only one the pipeline is not requesting in that cycle. `busy_o[q]` is 1 in the cycle after port q was taken.
- R5: While the pipeline requests every port in borrow mode, the unit takes no port and passes all pipeline addresses through unchanged. The pending check issues in the first cycle in which a port is free.
- R6: The queue holds 4 checks by default. A check that arrives while the queue is full is dropped; a pop in the same cycle does not make room. When reads arrive together, lower-numbered ports are queued first. `skip_o` pulses one cycle after the drop, and `skip_cnt_o` grows by the number dropped, saturating at its maximum value.
- R7: With `prot_en_i` = 1, only reads of `prot_addr_i` are checked. Reads of other addresses are never queued, take no port and raise no exception.
- R8: After reset, `exc_o`, `skip_o`, `skip_cnt_o` and all borrow activity are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 = reserved-port mode, 1 = borrow mode |
| prot_en_i | input | 1 | Limit checking to one address |
| prot_addr_i | input | AW | Protected register address |
| req_i | input | NPORT | Pipeline read request per port |
| addr_i | input | NPORT*AW | Pipeline read address per port |
| rf_en_o | output | NPORT | Read enable to the register file per port |
| rf_addr_o | output | NPORT*AW | Read address to the register file per port |
| rf_data_i | input | NPORT*DW | Read data per port, one cycle after enable |
| busy_o | output | NPORT | Port held by the unit; pipeline must not use it |
| exc_o | output | 1 | Mismatch exception pulse |
| exc_addr_o | output | AW | Address of the failing register |
| exc_port_o | output | PW | Port that made the primary read |
| skip_o | output | 1 | One or more checks dropped |
| skip_cnt_o | output | CNTW | Saturating count of dropped checks |

## Verification
A primary read presented in cycle t reaches the queue after two edges, so the verification read is visible on `rf_en_o`/`rf_addr_o` in cycle t+2. The bench samples it one nanosecond after that edge. `busy_o` for the taken port is expected in t+3, and the exception pulse in t+4, with its clearing checked in t+5. A drop caused by a read in cycle t shows on `skip_o` in t+2. Each directed task counts edges from its own request cycle and samples only at those offsets. For a rule such as "not taken" (R5) or "filtered" (R7), it samples the port enables in the cycles where a borrow would otherwise appear.

// File: rtl/rfchk_pkg.sv
// Package: shared definitions for the register file read cross-check unit.
// Assumes nothing beyond being compiled before every other module of the unit.
package rfchk_pkg;

    // Operating mode of the unit
    typedef enum logic {
        CHK_RESERVED = 1'b0,   // highest port belongs to the checker
        CHK_BORROW   = 1'b1    // idle ports are taken one at a time
    } chk_mode_e;

endpackage

// File: rtl/rfchk_capture.sv
// Module: rfchk_capture
// Registers, per port, whether the pipeline read in this cycle must be checked,
// together with its address. The register file returns the data one cycle later,
// which lines up with these registers.
// Assumes: the reserved port (NPORT-1) never carries a checked primary read in
// reserved mode; the protected-address filter applies when prot_en_i is high.
module rfchk_capture
    import rfchk_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int AW    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_i,
    input  logic                  prot_en_i,
    input  logic [AW-1:0]         prot_addr_i,
    input  logic [NPORT-1:0]      req_i,
    input  logic [NPORT*AW-1:0]   addr_i,
    output logic [NPORT-1:0]      cap_v_o,
    output logic [NPORT*AW-1:0]   cap_addr_o
);

    localparam int RES_PORT = NPORT - 1;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic qualifies;
        logic reserved_here;

        // Decide whether this port's read needs a check
        always_comb begin
            reserved_here = (mode_i == CHK_RESERVED) && (p == RES_PORT);
            qualifies = req_i[p] && !reserved_here &&
                        (!prot_en_i || (addr_i[p*AW +: AW] == prot_addr_i));
        end

        // Hold the qualifying flag and address for the data cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_v_o[p]              <= 1'b0;
                cap_addr_o[p*AW +: AW]  <= '0;
            end else begin
                cap_v_o[p]              <= qualifies;
                cap_addr_o[p*AW +: AW]  <= addr_i[p*AW +: AW];
            end
        end
    end

endmodule

// File: rtl/rfchk_queue.sv
// Module: rfchk_queue
// Circular queue of pending checks (port, address, primary data). It accepts
// several pushes per cycle in ascending port order and one pop per cycle.
// Pushes that find no room are dropped and counted on drop_n_o.
// Assumes: QDEPTH is a power of two, at least 2; pop_i only when head_v_o is high;
// room is the free space before this cycle's pop.
module rfchk_queue #(
    parameter int NPORT  = 4,
    parameter int AW     = 5,
    parameter int DW     = 32,
    parameter int QDEPTH = 4,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int QAW   = $clog2(QDEPTH),
    localparam int CW    = $clog2(QDEPTH + 1),
    localparam int DNW   = $clog2(NPORT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      push_v_i,
    input  logic [NPORT*AW-1:0]   push_addr_i,
    input  logic [NPORT*DW-1:0]   push_data_i,
    input  logic                  pop_i,
    output logic                  head_v_o,
    output logic [AW-1:0]         head_addr_o,
    output logic [DW-1:0]         head_data_o,
    output logic [PW-1:0]         head_port_o,
    output logic [DNW-1:0]        drop_n_o
);

    localparam int EW = PW + AW + DW;

    logic [EW-1:0]   slots_q [QDEPTH];
    logic [QAW-1:0]  rd_ptr_q;
    logic [CW-1:0]   fill_q;
    logic [CW-1:0]   room;
    logic [CW-1:0]   taken;
    logic [DNW-1:0]  dropped;
    logic [NPORT-1:0] accept;
    logic [QAW-1:0]  wr_idx [NPORT];

    // Assign a slot to each push in port order until the free room runs out
    always_comb begin
        room    = CW'(QDEPTH) - fill_q;
        taken   = '0;
        dropped = '0;
        for (int p = 0; p < NPORT; p++) begin
            accept[p] = 1'b0;
            wr_idx[p] = '0;
            if (push_v_i[p]) begin
                if (taken < room) begin
                    accept[p] = 1'b1;
                    wr_idx[p] = rd_ptr_q + fill_q[QAW-1:0] + taken[QAW-1:0];
                    taken     = taken + 1'b1;
                end else begin
                    dropped = dropped + 1'b1;
                end
            end
        end
    end

    // Advance the read pointer and the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            rd_ptr_q <= rd_ptr_q + QAW'(pop_i);
            fill_q   <= fill_q + taken - CW'(pop_i);
        end
    end

    // Write accepted entries into their slots
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (accept[p]) begin
                slots_q[wr_idx[p]] <= {PW'(p), push_addr_i[p*AW +: AW], push_data_i[p*DW +: DW]};
            end
        end
    end

    // Present the oldest entry
    always_comb begin
        head_v_o    = (fill_q != '0);
        {head_port_o, head_addr_o, head_data_o} = slots_q[rd_ptr_q];
        drop_n_o    = dropped;
    end

endmodule

// File: rtl/rfchk_issue.sv
// Module: rfchk_issue
// Chooses the port that carries the next check, steers the register file port
// inputs between pipeline and checker, and holds each issued check for the
// cycle in which its data returns.
// Assumes: register file read latency of one cycle; the pipeline honours busy_o.
module rfchk_issue
    import rfchk_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int AW    = 5,
    parameter int DW    = 32,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_i,
    input  logic [NPORT-1:0]      req_i,
    input  logic [NPORT*AW-1:0]   addr_i,
    input  logic                  head_v_i,
    input  logic [AW-1:0]         head_addr_i,
    input  logic [DW-1:0]         head_data_i,
    input  logic [PW-1:0]         head_port_i,
    output logic                  pop_o,
    output logic [NPORT-1:0]      rf_en_o,
    output logic [NPORT*AW-1:0]   rf_addr_o,
    output logic [NPORT-1:0]      busy_o,
    output logic [NPORT-1:0]      ver_v_o,
    output logic [NPORT*AW-1:0]   ver_addr_o,
    output logic [NPORT*DW-1:0]   ver_exp_o,
    output logic [NPORT*PW-1:0]   ver_src_o
);

    localparam int RES_PORT = NPORT - 1;

    logic             reserved_mode;
    logic [NPORT-1:0] usable;
    logic [NPORT-1:0] issue;
    logic             found;

    // Mark the ports a check may use this cycle
    always_comb begin
        reserved_mode = (mode_i == CHK_RESERVED);
        for (int q = 0; q < NPORT; q++) begin
            if (reserved_mode) begin
                usable[q] = (q == RES_PORT);
            end else begin
                usable[q] = !req_i[q] && !ver_v_o[q] && (head_port_i != PW'(q));
            end
        end
    end

    // Pick the lowest usable port for the head check
    always_comb begin
        issue = '0;
        found = 1'b0;
        for (int q = 0; q < NPORT; q++) begin
            if (!found && head_v_i && usable[q]) begin
                issue[q] = 1'b1;
                found    = 1'b1;
            end
        end
        pop_o = found;
    end

    for (genvar q = 0; q < NPORT; q++) begin : g_port
        logic owned;

        // Steer this port between pipeline and checker
        always_comb begin
            owned = reserved_mode && (q == RES_PORT);
            rf_en_o[q] = owned ? issue[q] : (req_i[q] | issue[q]);
            rf_addr_o[q*AW +: AW] = issue[q] ? head_addr_i : addr_i[q*AW +: AW];
            busy_o[q] = ver_v_o[q] | owned;
        end

        // Keep the issued check until its data returns
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ver_v_o[q]              <= 1'b0;
                ver_addr_o[q*AW +: AW]  <= '0;
                ver_exp_o[q*DW +: DW]   <= '0;
                ver_src_o[q*PW +: PW]   <= '0;
            end else begin
                ver_v_o[q] <= issue[q];
                if (issue[q]) begin
                    ver_addr_o[q*AW +: AW] <= head_addr_i;
                    ver_exp_o[q*DW +: DW]  <= head_data_i;
                    ver_src_o[q*PW +: PW]  <= head_port_i;
                end
            end
        end
    end

endmodule

// File: rtl/rfchk_compare.sv
// Module: rfchk_compare
// Compares returned verification data with the logged primary value and
// registers a one-cycle exception. If several ports mismatch together, the
// lowest-numbered one is reported.
// Assumes: ver_* inputs describe checks whose data is on rf_data_i this cycle.
module rfchk_compare #(
    parameter int NPORT = 4,
    parameter int AW    = 5,
    parameter int DW    = 32,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      ver_v_i,
    input  logic [NPORT*AW-1:0]   ver_addr_i,
    input  logic [NPORT*DW-1:0]   ver_exp_i,
    input  logic [NPORT*PW-1:0]   ver_src_i,
    input  logic [NPORT*DW-1:0]   rf_data_i,
    output logic                  exc_o,
    output logic [AW-1:0]         exc_addr_o,
    output logic [PW-1:0]         exc_port_o
);

    logic          hit;
    logic [AW-1:0] hit_addr;
    logic [PW-1:0] hit_src;

    // Find the first port whose re-read disagrees
    always_comb begin
        hit      = 1'b0;
        hit_addr = '0;
        hit_src  = '0;
        for (int q = 0; q < NPORT; q++) begin
            if (!hit && ver_v_i[q] && (rf_data_i[q*DW +: DW] != ver_exp_i[q*DW +: DW])) begin
                hit      = 1'b1;
                hit_addr = ver_addr_i[q*AW +: AW];
                hit_src  = ver_src_i[q*PW +: PW];
            end
        end
    end

    // Register the exception pulse and its payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_o      <= 1'b0;
            exc_addr_o <= '0;
            exc_port_o <= '0;
        end else begin
            exc_o <= hit;
            if (hit) begin
                exc_addr_o <= hit_addr;
                exc_port_o <= hit_src;
            end
        end
    end

endmodule

// File: rtl/regfile_read_checker.sv
// Module: regfile_read_checker (top)
// Cross-checks register file reads by re-reading each qualifying entry through
// a second port and comparing, in reserved-port or borrow mode. It also keeps a
// saturating count of checks dropped for lack of queue room.
// Assumes: one-cycle register file read latency, mode changes only while idle,
// pipeline obeys busy_o, QDEPTH a power of two.
module regfile_read_checker
    import rfchk_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int AW     = 5,
    parameter int DW     = 32,
    parameter int QDEPTH = 4,
    parameter int CNTW   = 8,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_i,
    input  logic                  prot_en_i,
    input  logic [AW-1:0]         prot_addr_i,
    input  logic [NPORT-1:0]      req_i,
    input  logic [NPORT*AW-1:0]   addr_i,
    output logic [NPORT-1:0]      rf_en_o,
    output logic [NPORT*AW-1:0]   rf_addr_o,
    input  logic [NPORT*DW-1:0]   rf_data_i,
    output logic [NPORT-1:0]      busy_o,
    output logic                  exc_o,
    output logic [AW-1:0]         exc_addr_o,
    output logic [PW-1:0]         exc_port_o,
    output logic                  skip_o,
    output logic [CNTW-1:0]       skip_cnt_o
);

    localparam int DNW = $clog2(NPORT + 1);

    logic [NPORT-1:0]    cap_v;
    logic [NPORT*AW-1:0] cap_addr;
    logic                head_v;
    logic [AW-1:0]       head_addr;
    logic [DW-1:0]       head_data;
    logic [PW-1:0]       head_port;
    logic [DNW-1:0]      drop_n;
    logic                pop;
    logic [NPORT-1:0]    ver_v;
    logic [NPORT*AW-1:0] ver_addr;
    logic [NPORT*DW-1:0] ver_exp;
    logic [NPORT*PW-1:0] ver_src;
    logic [CNTW:0]       skip_sum;

    rfchk_capture #(.NPORT(NPORT), .AW(AW)) capture_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .prot_en_i   (prot_en_i),
        .prot_addr_i (prot_addr_i),
        .req_i       (req_i),
        .addr_i      (addr_i),
        .cap_v_o     (cap_v),
        .cap_addr_o  (cap_addr)
    );

    rfchk_queue #(.NPORT(NPORT), .AW(AW), .DW(DW), .QDEPTH(QDEPTH)) queue_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_v_i    (cap_v),
        .push_addr_i (cap_addr),
        .push_data_i (rf_data_i),
        .pop_i       (pop),
        .head_v_o    (head_v),
        .head_addr_o (head_addr),
        .head_data_o (head_data),
        .head_port_o (head_port),
        .drop_n_o    (drop_n)
    );

    rfchk_issue #(.NPORT(NPORT), .AW(AW), .DW(DW)) issue_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .req_i       (req_i),
        .addr_i      (addr_i),
        .head_v_i    (head_v),
        .head_addr_i (head_addr),
        .head_data_i (head_data),
        .head_port_i (head_port),
        .pop_o       (pop),
        .rf_en_o     (rf_en_o),
        .rf_addr_o   (rf_addr_o),
        .busy_o      (busy_o),
        .ver_v_o     (ver_v),
        .ver_addr_o  (ver_addr),
        .ver_exp_o   (ver_exp),
        .ver_src_o   (ver_src)
    );

    rfchk_compare #(.NPORT(NPORT), .AW(AW), .DW(DW)) compare_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ver_v_i     (ver_v),
        .ver_addr_i  (ver_addr),
        .ver_exp_i   (ver_exp),
        .ver_src_i   (ver_src),
        .rf_data_i   (rf_data_i),
        .exc_o       (exc_o),
        .exc_addr_o  (exc_addr_o),
        .exc_port_o  (exc_port_o)
    );

    // Widened sum used to saturate the drop counter
    always_comb begin
        skip_sum = {1'b0, skip_cnt_o} + (CNTW+1)'(drop_n);
    end

    // Count dropped checks and pulse skip_o
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_o     <= 1'b0;
            skip_cnt_o <= '0;
        end else begin
            skip_o     <= (drop_n != '0);
            skip_cnt_o <= skip_sum[CNTW] ? {CNTW{1'b1}} : skip_sum[CNTW-1:0];
        end
    end

endmodule

// File: rtl/regfile_read_checker_sva.sv
// Module: rfchk_sva
// Checker bound to regfile_read_checker. It relates port activity across the
// capture, issue, compare and counter stages.
// Assumes: the same parameters as the bound instance.
module rfchk_sva #(
    parameter int NPORT = 4,
    parameter int CNTW  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_i,
    input logic [NPORT-1:0] req_i,
    input logic [NPORT-1:0] rf_en_o,
    input logic [NPORT-1:0] busy_o,
    input logic             exc_o,
    input logic             skip_o,
    input logic [CNTW-1:0]  skip_cnt_o
);

    logic [NPORT-1:0] taken;
    logic             unit_read;

    // Ports the checker drives this cycle, seen from the port pins
    always_comb begin
        taken     = rf_en_o & ~req_i;
        unit_read = mode_i ? (taken != '0) : rf_en_o[NPORT-1];
    end

    // R3
    reserve_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b0) |-> busy_o[NPORT-1]);

    // R4
    one_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> ($countones(taken) <= 1));

    for (genvar q = 0; q < NPORT; q++) begin : g_busy
        // R4
        borrow_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i && taken[q]) |=> busy_o[q]);
    end

    // R2
    exc_needs_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> $past(unit_read, 2));

    // R6
    skip_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> ((skip_cnt_o != $past(skip_cnt_o)) || (&skip_cnt_o)));

    // R6
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !skip_o |-> $stable(skip_cnt_o));

endmodule

bind regfile_read_checker rfchk_sva #(.NPORT(NPORT), .CNTW(CNTW)) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .req_i      (req_i),
    .rf_en_o    (rf_en_o),
    .busy_o     (busy_o),
    .exc_o      (exc_o),
    .skip_o     (skip_o),
    .skip_cnt_o (skip_cnt_o)
);

// File: tb/regfile_read_checker_tb_top.sv
`timescale 1ns/1ps
module regfile_read_checker_tb_top;

    localparam int NPORT = 4;
    localparam int AW    = 5;
    localparam int DW    = 32;
    localparam int PW    = 2;
    localparam int CNTW  = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  mode_i = 1'b1;
    logic                  prot_en_i = 1'b0;
    logic [AW-1:0]         prot_addr_i = '0;
    logic [NPORT-1:0]      req_i = '0;
    logic [NPORT*AW-1:0]   addr_i = '0;
    logic [NPORT-1:0]      rf_en_o;
    logic [NPORT*AW-1:0]   rf_addr_o;
    logic [NPORT*DW-1:0]   rf_data_i = '0;
    logic [NPORT-1:0]      busy_o;
    logic                  exc_o;
    logic [AW-1:0]         exc_addr_o;
    logic [PW-1:0]         exc_port_o;
    logic                  skip_o;
    logic [CNTW-1:0]       skip_cnt_o;

    logic [NPORT-1:0]      corrupt = '0;
    logic [DW-1:0]         regs [32];
    int                    n_chk = 0;
    int                    n_fail = 0;

    always #2.5 clk = ~clk;

    regfile_read_checker dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .prot_en_i(prot_en_i),
        .prot_addr_i(prot_addr_i), .req_i(req_i), .addr_i(addr_i),
        .rf_en_o(rf_en_o), .rf_addr_o(rf_addr_o), .rf_data_i(rf_data_i),
        .busy_o(busy_o), .exc_o(exc_o), .exc_addr_o(exc_addr_o),
        .exc_port_o(exc_port_o), .skip_o(skip_o), .skip_cnt_o(skip_cnt_o)
    );

    // Register file model: one-cycle latency, optional bit flip per port
    always @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            rf_data_i[p*DW +: DW] <= regs[rf_addr_o[p*AW +: AW]] ^ (corrupt[p] ? 32'h0000_0003 : 32'h0);
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        req_i = '0;
        corrupt = '0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_port(input int p, input logic [AW-1:0] a);
        req_i[p] = 1'b1;
        addr_i[p*AW +: AW] = a;
    endtask

    function automatic logic [AW-1:0] rfa(input int p);
        return rf_addr_o[p*AW +: AW];
    endfunction

    task automatic t_reset();
        check(exc_o == 1'b0, "R8 exc", 64'(exc_o), 0);
        check(skip_o == 1'b0, "R8 skip", 64'(skip_o), 0);
        check(skip_cnt_o == '0, "R8 skip_cnt", 64'(skip_cnt_o), 0);
        check(rf_en_o == '0, "R8 rf_en", 64'(rf_en_o), 0);
        check(busy_o == '0, "R8 busy", 64'(busy_o), 0);
    endtask

    task automatic t_clean_borrow();
        set_port(0, 5'd5);
        tick();                     // E1
        req_i = '0;
        tick();                     // E2: issue
        check(rf_en_o == 4'b0010, "R1 borrow port", 64'(rf_en_o), 64'b0010);
        check(rfa(1) == 5'd5, "R1 borrow addr", 64'(rfa(1)), 5);
        tick();                     // E3
        check(busy_o == 4'b0010, "R4 busy after borrow", 64'(busy_o), 64'b0010);
        tick();                     // E4
        check(exc_o == 1'b0, "R2 no exc on match", 64'(exc_o), 0);
        idle(6);
    endtask

    task automatic t_mismatch();
        set_port(2, 5'd7);
        corrupt[2] = 1'b1;
        tick();                     // E1
        req_i = '0;
        corrupt = '0;
        tick();                     // E2
        check(rf_en_o == 4'b0001, "R1 lowest other port", 64'(rf_en_o), 64'b0001);
        tick();                     // E3
        tick();                     // E4
        check(exc_o == 1'b1, "R2 exc pulse", 64'(exc_o), 1);
        check(exc_addr_o == 5'd7, "R2 exc addr", 64'(exc_addr_o), 7);
        check(exc_port_o == 2'd2, "R2 exc port", 64'(exc_port_o), 2);
        tick();                     // E5
        check(exc_o == 1'b0, "R2 exc one cycle", 64'(exc_o), 0);
        idle(6);
    endtask

    task automatic t_all_busy();
        prot_en_i = 1'b1;
        prot_addr_i = 5'd12;
        set_port(0, 5'd12);
        for (int p = 1; p < NPORT; p++) set_port(p, 5'd2);
        tick();                     // E1
        tick();                     // E2: entry queued, no free port
        check(rf_en_o == 4'b1111 && rfa(0) == 5'd12 && rfa(1) == 5'd2,
              "R5 no borrow while busy", 64'(rf_en_o), 64'b1111);
        tick();                     // E3
        check(busy_o == 4'b0000, "R5 nothing held", 64'(busy_o), 0);
        tick();                     // E4
        req_i = '0;
        #1;
        check(rf_en_o == 4'b0010 && rfa(1) == 5'd12, "R5 issue when freed",
              64'(rf_en_o), 64'b0010);
        idle(8);
        prot_en_i = 1'b0;
    endtask

    task automatic t_overflow();
        for (int p = 0; p < NPORT; p++) set_port(p, 5'(p + 20));
        tick();                     // E1
        tick();                     // E2: four queued, second batch on data bus
        req_i = '0;
        check(skip_o == 1'b0, "R6 first batch fits", 64'(skip_o), 0);
        tick();                     // E3: second batch dropped
        check(skip_o == 1'b1, "R6 skip pulse", 64'(skip_o), 1);
        check(skip_cnt_o == 8'd4, "R6 skip count", 64'(skip_cnt_o), 4);
        tick();                     // E4
        check(skip_o == 1'b0, "R6 skip one cycle", 64'(skip_o), 0);
        idle(10);
        check(exc_o == 1'b0, "R2 drained clean", 64'(exc_o), 0);
    endtask

    task automatic t_filter();
        prot_en_i = 1'b1;
        prot_addr_i = 5'd9;
        set_port(1, 5'd4);
        corrupt[1] = 1'b1;
        tick();
        req_i = '0;
        corrupt = '0;
        tick();                     // E2
        check(rf_en_o == 4'b0000, "R7 no borrow for other addr", 64'(rf_en_o), 0);
        tick();
        tick();                     // E4
        check(exc_o == 1'b0, "R7 no exc for other addr", 64'(exc_o), 0);
        idle(4);
        set_port(1, 5'd9);
        corrupt[1] = 1'b1;
        tick();
        req_i = '0;
        corrupt = '0;
        tick();
        tick();
        tick();                     // E4
        check(exc_o == 1'b1 && exc_addr_o == 5'd9 && exc_port_o == 2'd1,
              "R7 protected addr checked", 64'({exc_o, exc_addr_o, exc_port_o}), 64'({1'b1, 5'd9, 2'd1}));
        idle(6);
    endtask

    task automatic t_reserved();
        mode_i = 1'b0;
        prot_en_i = 1'b1;
        prot_addr_i = 5'd9;
        #1;
        check(busy_o[3] == 1'b1, "R3 reserved busy", 64'(busy_o), 64'b1000);
        set_port(0, 5'd1);
        set_port(1, 5'd9);
        set_port(2, 5'd1);
        set_port(3, 5'd9);
        corrupt[1] = 1'b1;
        tick();                     // E1
        addr_i[1*AW +: AW] = 5'd1;
        corrupt = '0;
        #1;
        check(rf_en_o[3] == 1'b0, "R3 pipeline req on reserved ignored", 64'(rf_en_o), 64'b0111);
        tick();                     // E2
        check(rf_en_o == 4'b1111 && rfa(3) == 5'd9, "R3 check on reserved port",
              64'(rf_en_o), 64'b1111);
        tick();                     // E3
        check(rf_en_o[3] == 1'b0, "R3 no spurious reserved read", 64'(rf_en_o), 64'b0111);
        tick();                     // E4
        check(exc_o == 1'b1 && exc_addr_o == 5'd9 && exc_port_o == 2'd1,
              "R3 exc in reserved mode", 64'({exc_o, exc_addr_o, exc_port_o}), 64'({1'b1, 5'd9, 2'd1}));
        idle(6);
        mode_i = 1'b1;
        prot_en_i = 1'b0;
        idle(2);
    endtask

    task automatic t_saturate();
        for (int p = 0; p < NPORT; p++) set_port(p, 5'd3);
        for (int i = 0; i < 70; i++) tick();
        idle(10);
        check(skip_cnt_o == 8'hFF, "R6 skip count saturates", 64'(skip_cnt_o), 64'hFF);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 32'hC3A5_0000 + 32'(i * 32'h0001_0203);
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_clean_borrow();
        t_mismatch();
        t_all_busy();
        t_overflow();
        t_filter();
        t_reserved();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule